// File: doc/BRIEF.md
# Reflected CRC-16 Byte Accumulator

This block keeps a running 16-bit checksum over a stream of bytes that software or a DMA engine writes into it one at a time. Every accepted byte is folded into the checksum with the x^16 + x^12 + x^5 + 1 generator. Bit 0 of the byte goes into the division first, and the remainder is kept in reflected bit order. A multi-byte word therefore goes in low byte first, which suits serial links that send the least significant bit first. The checksum register can be read at any time. Writing it loads a starting seed. No final inversion is applied.

The register port has a write strobe, a two-bit write select (bit 0 targets the byte register, bit 1 targets the checksum register), 16 bits of write data, a read select and a ready flag. A byte sequencer with two states, `ST_IDLE` and `ST_SHIFT`, controls the folding. The parameter `STEPS_PER_CYCLE` sets how many bits are folded per clock and must divide 8. With the default of 8, a whole byte is folded on the edge that writes it and the sequencer never leaves `ST_IDLE`. With a smaller value, an accepted byte folds its first chunk on the write edge, takes transition `start_chunks` into `ST_SHIFT`, and folds the rest one chunk per cycle. Transition `last_chunk` returns it to `ST_IDLE` after the final chunk, and transition `seed_abort` returns it there at once whenever the checksum register is written. In `ST_SHIFT` the ready flag is low and byte writes are dropped.

Top module: `crc16_byte_engine`

## Requirements
- R1: Each accepted byte write folds `wdata[7:0]` into the checksum: the checksum is XORed with the byte in its low 8 bits, then shifted right eight times, XORing in 16'h8408 whenever the bit shifted out is 1. This equals bit-reversing the byte, dividing MSB first by 16'h1021, and bit-reversing the remainder. `wdata[15:8]` is ignored.
- R2: From a 0000h start, writing bytes 78h, 56h, 34h and 12h in that order leaves 08F6h in the checksum register.
- R3: After reset the byte register reads 00h, the checksum reads 0000h and `ready` is 1.
- R4: A write with `wr_sel[1]` set loads `wdata` into the checksum unchanged. Reading it back with no bytes in between returns that seed exactly, since no final XOR is applied. Later bytes fold from the seed.
- R5: An accepted byte write stores `wdata[7:0]` in the byte register. With `rd_sel` = 0, `rdata` reads {8'h00, byte}.
- R6: When `wr_sel` = 2'b11, the checksum takes the seed and the byte is not folded. The byte register still captures the byte.
- R7: `rdata` with `rd_sel` = 1 shows the updated checksum in the cycle after the write edge. While no write occurs, the checksum holds its value.
- R8: With `STEPS_PER_CYCLE` = 8, `ready` stays 1 through back-to-back byte writes. In `ST_SHIFT`, byte writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: bit 0 byte register, bit 1 checksum register |
| wdata | input | 16 | Write data (byte register uses bits 7:0) |
| rd_sel | input | 1 | Read target: 0 byte register, 1 checksum |
| rdata | output | 16 | Read data of the selected register |
| ready | output | 1 | High when a byte write will be accepted |

## Verification
A byte fold and a seed load can both target the checksum register in one cycle. The bench provokes this by driving `wr_sel` = 2'b11 with a distinct seed and byte. It then judges the next-cycle checksum against the seed alone, and the byte register against the byte. Every other byte write is scored against a bit-serial model that works in the normal, non-reflected domain, including 24-byte back-to-back streams that start from random seeds.

// File: rtl/crc16_pkg.sv
package crc16_pkg;

    localparam logic [15:0] POLY_REFL = 16'h8408;

    typedef enum logic {
        ST_IDLE,
        ST_SHIFT
    } seq_state_t;

endpackage

// File: rtl/crc16_fold.sv
module crc16_fold #(
    parameter int          STEPS = 8,
    parameter logic [15:0] POLY  = 16'h8408
) (
    input  logic [15:0]      crc_in,
    input  logic [STEPS-1:0] bits_in,
    output logic [15:0]      crc_out
);

    for (genvar i = 0; i < STEPS; i++) begin : g_step
        logic [15:0] prev;
        logic [15:0] nxt;
        logic        fb;
        if (i == 0) begin : g_first
            assign prev = crc_in;
        end else begin : g_chain
            assign prev = g_step[i-1].nxt;
        end
        assign fb  = prev[0] ^ bits_in[i];
        assign nxt = {1'b0, prev[15:1]} ^ (fb ? POLY : 16'h0000);
    end

    assign crc_out = g_step[STEPS-1].nxt;

endmodule

// File: rtl/crc16_seq.sv
module crc16_seq
    import crc16_pkg::*;
#(
    parameter int STEPS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_wr,
    input  logic             seed_wr,
    input  logic [7:0]       byte_in,
    output logic             ready,
    output logic             byte_accept,
    output logic             fold_en,
    output logic [STEPS-1:0] fold_bits
);

    localparam int CHUNKS = 8 / STEPS;
    localparam int CW     = $clog2(CHUNKS + 1);

    seq_state_t    state_q, state_d;
    logic [7:0]    sh_q, sh_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sh_q    <= 8'h00;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            sh_q    <= sh_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        sh_d    = sh_q;
        cnt_d   = cnt_q;
        if (seed_wr) begin
            state_d = ST_IDLE;               // seed_abort
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (byte_wr && CHUNKS > 1) begin
                        state_d = ST_SHIFT;  // start_chunks
                        sh_d    = byte_in >> STEPS;
                        cnt_d   = CW'(CHUNKS - 1);
                    end
                end
                ST_SHIFT: begin
                    sh_d  = sh_q >> STEPS;
                    cnt_d = cnt_q - 1'b1;
                    if (cnt_q == CW'(1)) begin
                        state_d = ST_IDLE;   // last_chunk
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        ready       = (state_q == ST_IDLE);
        byte_accept = byte_wr && (state_q == ST_IDLE);
        fold_en     = (byte_accept || state_q == ST_SHIFT) && !seed_wr;
        fold_bits   = (state_q == ST_IDLE) ? byte_in[STEPS-1:0] : sh_q[STEPS-1:0];
    end

    assert_shift_has_work_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT) |-> (cnt_q != '0));

endmodule

// File: rtl/crc16_byte_engine.sv
module crc16_byte_engine
    import crc16_pkg::*;
#(
    parameter int STEPS_PER_CYCLE = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [15:0] wdata,
    input  logic        rd_sel,
    output logic [15:0] rdata,
    output logic        ready
);

    logic                       byte_wr, seed_wr;
    logic                       byte_accept, fold_en;
    logic [STEPS_PER_CYCLE-1:0] fold_bits;
    logic [15:0]                fold_out;
    logic [15:0]                crc_q;
    logic [7:0]                 in_q;

    assign byte_wr = wr_en && wr_sel[0];
    assign seed_wr = wr_en && wr_sel[1];

    crc16_seq #(.STEPS(STEPS_PER_CYCLE)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_wr     (byte_wr),
        .seed_wr     (seed_wr),
        .byte_in     (wdata[7:0]),
        .ready       (ready),
        .byte_accept (byte_accept),
        .fold_en     (fold_en),
        .fold_bits   (fold_bits)
    );

    crc16_fold #(.STEPS(STEPS_PER_CYCLE), .POLY(POLY_REFL)) u_fold (
        .crc_in  (crc_q),
        .bits_in (fold_bits),
        .crc_out (fold_out)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= 16'h0000;
            in_q  <= 8'h00;
        end else begin
            if (byte_accept) in_q <= wdata[7:0];
            if (seed_wr)      crc_q <= wdata;
            else if (fold_en) crc_q <= fold_out;
        end
    end

    assign rdata = rd_sel ? crc_q : {8'h00, in_q};

    assert_seed_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'b10) |=> (crc_q == $past(wdata)));

    assert_seed_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'b11) |=> (crc_q == $past(wdata)));

    assert_byte_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_wr && ready) |=> (in_q == $past(wdata[7:0])));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && ready) |=> $stable(crc_q));

    assert_busy_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_wr && !ready) |=> $stable(in_q));

endmodule

// File: tb/test_crc16_byte_engine.sv
module test_crc16_byte_engine;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [15:0] wdata;
    logic        rd_sel;
    logic [15:0] rdata;
    logic        ready;

    always #5 clk = ~clk;

    crc16_byte_engine i_crc16_byte_engine (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wdata(wdata), .rd_sel(rd_sel), .rdata(rdata), .ready(ready)
    );

    typedef struct {
        logic [15:0] exp;
        string       req;
    } sb_item_t;

    sb_item_t    sb_q[$];
    sb_item_t    mon_item;
    int          checks   = 0;
    int          failures = 0;
    logic [15:0] model    = 16'h0000;
    logic [15:0] held;
    bit          finished = 1'b0;

    function automatic logic [15:0] rev16(input logic [15:0] v);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = v[15-i];
        return r;
    endfunction

    // bit-serial model in the normal domain, MSB first, on the reversed byte
    function automatic logic [15:0] ref_fold(input logic [15:0] crc_refl, input logic [7:0] b);
        logic [15:0] r;
        logic        top;
        r = rev16(crc_refl);
        for (int i = 0; i < 8; i++) begin
            top = r[15] ^ b[i];
            r   = {r[14:0], 1'b0};
            if (top) r = r ^ 16'h1021;
        end
        return rev16(r);
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: score every write one step after its edge
    always @(posedge clk) begin
        if (rst_n && wr_en && wr_sel != 2'b00) begin
            #2;
            if (sb_q.size() == 0) begin
                check("R1 scoreboard empty", 16'h0001, 16'h0000);
            end else begin
                mon_item = sb_q.pop_front();
                check(mon_item.req, rdata, mon_item.exp);
                check("R8 ready during stream", {15'b0, ready}, 16'h0001);
            end
        end
    end

    // drivers: called at a falling edge, return at the next falling edge
    task automatic put_byte(input logic [7:0] b);
        wr_en  = 1'b1;
        wr_sel = 2'b01;
        wdata  = {~b, b};
        rd_sel = 1'b1;
        model  = ref_fold(model, b);
        sb_q.push_back('{model, "R1 byte fold"});
        @(negedge clk);
    endtask

    task automatic put_seed(input logic [15:0] s);
        wr_en  = 1'b1;
        wr_sel = 2'b10;
        wdata  = s;
        rd_sel = 1'b1;
        model  = s;
        sb_q.push_back('{model, "R4 seed load"});
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        wr_en  = 1'b0;
        wr_sel = 2'b00;
        rd_sel = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n  = 1'b0;
        wr_en  = 1'b0;
        wr_sel = 2'b00;
        wdata  = 16'h0000;
        rd_sel = 1'b0;
        repeat (3) @(negedge clk);
        #1 check("R3 byte reg reset", rdata, 16'h0000);
        rd_sel = 1'b1;
        #1 check("R3 checksum reset", rdata, 16'h0000);
        check("R3 ready reset", {15'b0, ready}, 16'h0001);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 known vector, back to back
        put_byte(8'h78);
        put_byte(8'h56);
        put_byte(8'h34);
        put_byte(8'h12);
        idle(1);
        check("R2 vector result", rdata, 16'h08F6);
        rd_sel = 1'b0;
        #1 check("R5 byte reg readback", rdata, 16'h0012);

        // R7 hold with no writes
        idle(1);
        held = rdata;
        idle(6);
        check("R7 checksum holds", rdata, held);

        // R4 / R1 random streams from random seeds
        for (int round = 0; round < 3; round++) begin
            logic [7:0] last;
            put_seed(16'($urandom()));
            for (int k = 0; k < 24; k++) begin
                last = 8'($urandom());
                put_byte(last);
            end
            idle(1);
            check("R1 stream end", rdata, model);
            rd_sel = 1'b0;
            #1 check("R5 last byte", rdata, {8'h00, last});
            idle(1);
        end

        // R4 seed then bytes
        put_seed(16'h1D0F);
        put_byte(8'h00);
        put_byte(8'hFF);
        idle(1);

        // R6 simultaneous seed and byte
        wr_en  = 1'b1;
        wr_sel = 2'b11;
        wdata  = 16'hBEEF;
        rd_sel = 1'b1;
        model  = 16'hBEEF;
        sb_q.push_back('{model, "R6 seed wins"});
        @(negedge clk);
        idle(1);
        check("R6 checksum is seed", rdata, 16'hBEEF);
        rd_sel = 1'b0;
        #1 check("R6 byte captured", rdata, 16'h00EF);
        idle(1);
        put_byte(8'h5A);
        idle(2);
        check("R6 fold after seed", rdata, ref_fold(16'hBEEF, 8'h5A));

        check("R1 scoreboard drained", 16'(sb_q.size()), 16'h0000);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule